// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block scans a matrix keypad on its own and makes the result available through a small register interface. It drives one row line low at a time and holds it for a programmable settle time. It then samples the column lines and stores the row as a 16-bit halfword. Keys are active-low, so a pressed key reads 0 in its data bit and an idle row reads 0xFFFF.

Software picks one of four modes:
- Idle.
- Any-key detect: every row is driven at once and the data registers are left alone.
- Single scan: runs once, then drops the mode field back to idle by itself.
- Continuous scan: waits a programmable gap between passes.

A size register limits how many rows are scanned and how many columns count as real. Three event flags are kept in a write-one-to-clear status register, and a mask register gates them onto a single interrupt line.

Top module: `kpd_scan_top`

## Requirements
- R1: After reset, control, size, status and mask read 0, every data halfword reads 0xFFFF, all row lines are high and the interrupt is low.
- R2: Register map, word addresses: control at 0x00, size at 0x04, status at 0x08, mask at 0x0C. Data word 0x10+4k holds row 2k in bits 15:0 and row 2k+1 in bits 31:16.
- R3: Control bits 1:0 select the mode: 0 idle, 1 any-key, 2 single, 3 continuous. Bits 15:2 are the settle count S. During a scan each row, in ascending order, is the only row driven low, for exactly S+1 cycles, and its columns are sampled in the last of those cycles.
- R4: Single scan (mode 2) stores each scanned row with pressed keys as 0 bits. When the pass ends, the mode field reads 0 and the other control bits are kept.
- R5: Size bits 15:8 give the column count C. In every stored row, bits at positions C and above read 1 whatever the keys are.
- R6: Size bits 7:0 give the row count N. Rows at index N and above are not written and keep their earlier contents.
- R7: Status bit 0 is set at the end of each pass. Status bit 1 is set only when a stored row differs from its old value.
- R8: Writing 1s to status clears those bits. The interrupt is high exactly when some status bit and its mask bit, at the same position, are both 1.
- R9: In mode 1 all rows are driven low and no data register changes. A pressed key sets status bit 2, which cannot be cleared while the key is held and can be cleared after it is released.
- R10: In mode 3, control bits 31:16 give the gap G. Between passes all rows stay high for exactly G+1 cycles, and passes repeat with the mode staying 3.
- R11: Writing mode 0 or 1 during a scan aborts it: rows go high and no scan-complete flag follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| row_drv_n | output | NROW | Row drive lines, active low |
| col_in_n | input | NCOL | Column sense lines, low when a key on a driven row is pressed |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a pass that ends up with a row that was scanned earlier but now falls outside a smaller row count, next to a pass that changes nothing. Only the stored contents and the change flag tell these two apart. The stimulus runs several single passes over a modelled key matrix, shrinking and growing the row count between them, and reads the data words after each pass. It also runs one pass with the keys unchanged to check that the change flag stays clear. Aborting a continuous scan in mid-pass is timed by watching the row lines and issuing the control write while a chosen row is being driven.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int unsigned HW_W     = 16;
  localparam int unsigned MAX_ROWS = 16;
  localparam int unsigned CNT_W    = 16;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ANY  = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_LOOP = 2'd3
  } kpd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_GAP    = 2'd2
  } kpd_state_e;
endpackage

// File: rtl/kpd_scan_fsm.sv
module kpd_scan_fsm
  import kpd_pkg::*;
#(
  parameter int unsigned NROW = 16,
  parameter int unsigned NCOL = 16,
  localparam int unsigned RW  = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  kpd_mode_e       mode,
  input  logic [13:0]     settle,
  input  logic [15:0]     gap,
  input  logic [7:0]      nrows,
  input  logic [7:0]      ncols,
  input  logic [NCOL-1:0] col_in_n,
  output logic [NROW-1:0] row_drv_n,
  output logic            wr_en,
  output logic [RW-1:0]   wr_row,
  output logic [HW_W-1:0] wr_data,
  output logic            done_pulse,
  output logic            clr_mode,
  output logic            key_any
);
  kpd_state_e       state_q, state_d;
  logic [RW-1:0]    row_q, row_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [8:0]       eff_rows;
  logic             run_mode;
  logic             sample;
  logic             last_row;

  assign eff_rows = ({1'b0, nrows} > 9'(NROW)) ? 9'(NROW) : {1'b0, nrows};
  assign run_mode = (mode == MODE_ONCE) || (mode == MODE_LOOP);
  assign sample   = (state_q == ST_SETTLE) && run_mode &&
                    (cnt_q >= {{(CNT_W-14){1'b0}}, settle});
  assign last_row = ({{(9-RW){1'b0}}, row_q} + 9'd1) >= eff_rows;

  // Column conditioning: positions past the configured count read released.
  for (genvar c = 0; c < HW_W; c++) begin : g_col
    if (c < NCOL) begin : g_real
      assign wr_data[c] = (8'(c) < ncols) ? col_in_n[c] : 1'b1;
    end else begin : g_pad
      assign wr_data[c] = 1'b1;
    end
  end

  assign wr_en      = sample && ({{(9-RW){1'b0}}, row_q} < eff_rows);
  assign wr_row     = row_q;
  assign done_pulse = sample && last_row;
  assign clr_mode   = done_pulse && (mode == MODE_ONCE);
  assign key_any    = (mode == MODE_ANY) && !(&col_in_n);

  always_comb begin
    if (mode == MODE_ANY) begin
      row_drv_n = '0;
    end else if (state_q == ST_SETTLE) begin
      row_drv_n = ~(NROW'(1) << row_q);
    end else begin
      row_drv_n = '1;
    end
  end

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (run_mode) begin
          state_d = ST_SETTLE;
          row_d   = '0;
          cnt_d   = '0;
        end
      end
      ST_SETTLE: begin
        if (!run_mode) begin
          state_d = ST_IDLE;
        end else if (sample) begin
          cnt_d = '0;
          if (last_row) begin
            state_d = (mode == MODE_LOOP) ? ST_GAP : ST_IDLE;
            row_d   = '0;
          end else begin
            row_d = row_q + RW'(1);
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (!run_mode) begin
          state_d = ST_IDLE;
        end else if (cnt_q >= gap) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      cnt_q   <= cnt_d;
    end
  end

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !run_mode) |=> (state_q == ST_IDLE));
  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && run_mode && !sample) |=> ($stable(row_q) && state_q == ST_SETTLE));
endmodule

// File: rtl/kpd_rowstore.sv
module kpd_rowstore
  import kpd_pkg::*;
#(
  parameter int unsigned NROW = 16,
  localparam int unsigned RW  = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_row,
  input  logic [HW_W-1:0]      wr_data,
  output logic [NROW*HW_W-1:0] rows_flat,
  output logic                 changed
);
  logic [HW_W-1:0] cur;

  assign cur     = rows_flat[wr_row*HW_W +: HW_W];
  assign changed = wr_en && (cur != wr_data);

  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic hit;
    assign hit = wr_en && (wr_row == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rows_flat[r*HW_W +: HW_W] <= '1;
      end else if (hit) begin
        rows_flat[r*HW_W +: HW_W] <= wr_data;
      end
    end
  end

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rows_flat));
endmodule

// File: rtl/kpd_regs.sv
module kpd_regs
  import kpd_pkg::*;
#(
  parameter int unsigned NROW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NROW*HW_W-1:0] rows_flat,
  input  logic                 done_pulse,
  input  logic                 changed,
  input  logic                 key_any,
  input  logic                 clr_mode,
  output kpd_mode_e            mode,
  output logic [13:0]          settle,
  output logic [15:0]          gap,
  output logic [7:0]           nrows,
  output logic [7:0]           ncols,
  output logic                 irq
);
  localparam int unsigned PAD_W = MAX_ROWS * HW_W;

  logic [31:0] ctrl_q, ctrl_d;
  logic [15:0] size_q, size_d;
  logic [2:0]  sts_q, sts_d, mask_q, mask_d;
  logic [2:0]  sts_set, sts_clr;
  logic        wr_ctrl, wr_size, wr_sts, wr_mask;
  logic [5:0]  widx;
  logic [2:0]  didx;
  logic [PAD_W-1:0] rows_pad;

  assign widx    = bus_addr[7:2];
  assign wr_ctrl = bus_we && (widx == 6'd0);
  assign wr_size = bus_we && (widx == 6'd1);
  assign wr_sts  = bus_we && (widx == 6'd2);
  assign wr_mask = bus_we && (widx == 6'd3);

  assign sts_set = {key_any, changed, done_pulse};
  assign sts_clr = wr_sts ? bus_wdata[2:0] : 3'b000;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = bus_wdata;
    end else if (clr_mode) begin
      ctrl_d[1:0] = 2'b00;
    end
    size_d = wr_size ? bus_wdata[15:0] : size_q;
    mask_d = wr_mask ? bus_wdata[2:0] : mask_q;
    sts_d  = sts_set | (sts_q & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
      mask_q <= '0;
      sts_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      size_q <= size_d;
      mask_q <= mask_d;
      sts_q  <= sts_d;
    end
  end

  assign mode   = kpd_mode_e'(ctrl_q[1:0]);
  assign settle = ctrl_q[15:2];
  assign gap    = ctrl_q[31:16];
  assign nrows  = size_q[7:0];
  assign ncols  = size_q[15:8];
  assign irq    = |(sts_q & mask_q);

  always_comb begin
    rows_pad = '0;
    rows_pad[NROW*HW_W-1:0] = rows_flat;
  end

  assign didx = 3'(widx - 6'd4);

  always_comb begin
    bus_rdata = '0;
    if (widx == 6'd0) begin
      bus_rdata = ctrl_q;
    end else if (widx == 6'd1) begin
      bus_rdata = {16'd0, size_q};
    end else if (widx == 6'd2) begin
      bus_rdata = {29'd0, sts_q};
    end else if (widx == 6'd3) begin
      bus_rdata = {29'd0, mask_q};
    end else if (widx >= 6'd4 && widx < 6'd12) begin
      bus_rdata = rows_pad[didx*32 +: 32];
    end
  end

  assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_any |=> sts_q[2]);
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && bus_wdata[0] && !done_pulse) |=> !sts_q[0]);
  assert_self_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && !wr_ctrl) |=> (ctrl_q[1:0] == 2'b00));
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top
  import kpd_pkg::*;
#(
  parameter int unsigned NROW = 16,
  parameter int unsigned NCOL = 16,
  localparam int unsigned RW  = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NROW-1:0] row_drv_n,
  input  logic [NCOL-1:0] col_in_n,
  output logic            irq
);
  kpd_mode_e            mode;
  logic [13:0]          settle;
  logic [15:0]          gap;
  logic [7:0]           nrows, ncols;
  logic                 wr_en, done_pulse, clr_mode, key_any, changed;
  logic [RW-1:0]        wr_row;
  logic [HW_W-1:0]      wr_data;
  logic [NROW*HW_W-1:0] rows_flat;

  kpd_regs #(.NROW(NROW)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rows_flat(rows_flat),
    .done_pulse(done_pulse), .changed(changed), .key_any(key_any),
    .clr_mode(clr_mode), .mode(mode), .settle(settle), .gap(gap),
    .nrows(nrows), .ncols(ncols), .irq(irq)
  );

  kpd_scan_fsm #(.NROW(NROW), .NCOL(NCOL)) fsm_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .settle(settle), .gap(gap),
    .nrows(nrows), .ncols(ncols), .col_in_n(col_in_n), .row_drv_n(row_drv_n),
    .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .done_pulse(done_pulse), .clr_mode(clr_mode), .key_any(key_any)
  );

  kpd_rowstore #(.NROW(NROW)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .rows_flat(rows_flat), .changed(changed)
  );

  assert_one_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ANY) |-> ($countones(~row_drv_n) <= 1));
  assert_any_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ANY) |-> (row_drv_n == '0));
endmodule

// File: tb/kpd_scan_top_tb_top.sv
module kpd_scan_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [15:0] row_drv_n;
  logic [15:0] col_in_n;
  logic        irq;
  logic [15:0] keys [16];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] obs_q [$];

  always #5 clk = ~clk;

  kpd_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_drv_n(row_drv_n),
    .col_in_n(col_in_n), .irq(irq)
  );

  // Keypad matrix model: a column is pulled low by any pressed key on a driven row.
  always_comb begin
    for (int c = 0; c < 16; c++) begin
      col_in_n[c] = 1'b1;
      for (int r = 0; r < 16; r++) begin
        if (keys[r][c] && !row_drv_n[r]) col_in_n[c] = 1'b0;
      end
    end
  end

  // Scoreboard monitor: pairs expected items with observed ones.
  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      logic [31:0] e, o;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      o = obs_q.pop_front();
      total++;
      if (o !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, o, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic expect_item(input string tag, input logic [31:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [31:0] v);
    obs_q.push_back(v);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] e);
    logic [31:0] v;
    expect_item(tag, e);
    rd(a, v);
    observe(v);
    @(negedge clk);
  endtask

  task automatic chk_val(input string tag, input logic [31:0] o, input logic [31:0] e);
    expect_item(tag, e);
    observe(o);
    @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(8'h08, v);
      if (v[0]) break;
    end
  endtask

  task automatic wait_rows(input logic [15:0] pat);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (row_drv_n == pat) break;
    end
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 16; r++) keys[r] = 16'h0;
  endtask

  initial begin
    int n;
    clear_keys();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg("R1 ctrl", 8'h00, 32'h0);
    chk_reg("R1 size", 8'h04, 32'h0);
    chk_reg("R1 status", 8'h08, 32'h0);
    chk_reg("R1 mask", 8'h0C, 32'h0);
    chk_reg("R1 data", 8'h10, 32'hFFFF_FFFF);
    chk_val("R1 rows", {16'h0, row_drv_n}, 32'h0000_FFFF);
    chk_val("R1 irq", {31'h0, irq}, 32'h0);

    // Pass 1: 4 rows, 6 columns, settle 3
    keys[0][1] = 1'b1; keys[2][5] = 1'b1; keys[3][7] = 1'b1; keys[5][0] = 1'b1;
    wr(8'h04, 32'h0000_0604);
    wr(8'h0C, 32'h7);
    chk_reg("R2 size readback", 8'h04, 32'h0000_0604);
    wr(8'h00, 32'h0000_000E);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (row_drv_n == 16'hFFFE) n++;
      else if (n > 0) break;
    end
    chk_val("R3 settle length", n, 32'd4);
    wait_done();
    chk_reg("R4 mode back to 0", 8'h00, 32'h0000_000C);
    chk_reg("R4 row0/1 data", 8'h10, 32'hFFFF_FFFD);
    chk_reg("R5 col beyond count", 8'h14, 32'hFFFF_FFDF);
    chk_reg("R6 rows beyond count", 8'h18, 32'hFFFF_FFFF);
    chk_reg("R7 done+changed", 8'h08, 32'h3);
    chk_val("R8 irq on", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h3);
    chk_reg("R8 w1c", 8'h08, 32'h0);
    chk_val("R8 irq off", {31'h0, irq}, 32'h0);

    // Pass 2: 8 rows, mask off
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h0000_0608);
    wr(8'h00, 32'h0000_000E);
    wait_done();
    chk_reg("R4 row4/5 data", 8'h18, 32'hFFFE_FFFF);
    chk_reg("R7 change on new row", 8'h08, 32'h3);
    chk_val("R8 masked irq", {31'h0, irq}, 32'h0);
    wr(8'h0C, 32'h1);
    chk_val("R8 unmasked irq", {31'h0, irq}, 32'h1);

    // Pass 3: identical keys, no change flag expected
    wr(8'h08, 32'h7);
    wr(8'h0C, 32'h7);
    wr(8'h00, 32'h0000_000E);
    wait_done();
    chk_reg("R7 no change", 8'h08, 32'h1);

    // Pass 4: release keys, scan only 2 rows, 16 columns
    clear_keys();
    wr(8'h08, 32'h7);
    wr(8'h04, 32'h0000_1002);
    wr(8'h00, 32'h0000_000E);
    wait_done();
    chk_reg("R4 released", 8'h10, 32'hFFFF_FFFF);
    chk_reg("R6 row2 kept", 8'h14, 32'hFFFF_FFDF);
    chk_reg("R6 row5 kept", 8'h18, 32'hFFFE_FFFF);
    chk_reg("R7 status pass4", 8'h08, 32'h3);

    // Mode 1: any-key detect
    wr(8'h08, 32'h7);
    wr(8'h00, 32'h0000_0001);
    @(negedge clk);
    chk_val("R9 all rows driven", {16'h0, row_drv_n}, 32'h0);
    keys[0][2] = 1'b1;
    repeat (3) @(negedge clk);
    chk_reg("R9 key flag", 8'h08, 32'h4);
    wr(8'h08, 32'h4);
    chk_reg("R9 flag held", 8'h08, 32'h4);
    chk_reg("R9 no data update", 8'h10, 32'hFFFF_FFFF);
    keys[0][2] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h08, 32'h4);
    chk_reg("R9 flag cleared", 8'h08, 32'h0);

    // Mode 3: continuous, gap 20, settle 5, 4 rows
    wr(8'h00, 32'h0);
    chk_val("R11 rows released", {16'h0, row_drv_n}, 32'h0000_FFFF);
    keys[1][3] = 1'b1;
    wr(8'h04, 32'h0000_1004);
    wr(8'h00, (32'd20 << 16) | (32'd5 << 2) | 32'd3);
    wait_rows(16'hFFF7);
    wait_rows(16'hFFFF);
    n = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (row_drv_n == 16'hFFFF) n++;
      else break;
    end
    chk_val("R10 gap length", n, 32'd21);
    chk_val("R10 next pass row0", {16'h0, row_drv_n}, 32'h0000_FFFE);
    chk_reg("R10 data", 8'h10, 32'hFFF7_FFFF);
    keys[1][3] = 1'b0; keys[1][4] = 1'b1;
    wr(8'h08, 32'h7);
    wait_done();
    wr(8'h08, 32'h7);
    wait_done();
    chk_reg("R10 data updated", 8'h10, 32'hFFEF_FFFF);
    chk_reg("R10 mode kept", 8'h00, (32'd20 << 16) | (32'd5 << 2) | 32'd3);

    // Abort in mid-pass
    wait_rows(16'hFFFE);
    wr(8'h08, 32'h7);
    wait_rows(16'hFFFD);
    wr(8'h00, 32'h0);
    repeat (40) @(negedge clk);
    chk_reg("R11 no done after abort", 8'h08, 32'h0);
    chk_val("R11 rows high", {16'h0, row_drv_n}, 32'h0000_FFFF);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard residue actual=%0d expected=%0d", obs_q.size(), exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule